// File: doc/BRIEF.md
# Prescaled Up-Counting Timer

A register-mapped timer with a 16-bit counter. Software selects a tick rate and a counting window. The counter climbs from a start value to a wrap value and then reloads the start value. Each reload raises a sticky wrap flag, and that flag can raise an interrupt line.

Ticks come from the system clock. The clock is divided by a power of two, from 1 to 128. The counting source is chosen by a two-bit field, and only one code of that field runs the counter. The wrap and start values are written into shadow buffers. These buffers reach the live comparison only while the counting source is switched off. A running period therefore cannot be disturbed by software. A write of any data to the counter register restarts it at the start value.

Top module: `pscl_up_timer`

## Requirements
- R1: After a synchronous active-high reset, every register reads 0 and `irq_o` is low.
- R2: The registers are at these byte addresses: 0x00 control, 0x04 counter, 0x08 wrap value, 0x4C start value. Only bits 15:0 of the counter, wrap and start registers are stored, and reads of those registers return zero in bits 31:16.
- R3: Control bits 4:3 select the counting source. Code 1 runs the counter from the system clock. Codes 0, 2 and 3 hold the counter at its value.
- R4: Control bits 2:0 hold a divide exponent P. The counter steps once every 2^P clock cycles. The divider is cleared while the source code is not 1, so the first step after enabling comes 2^P cycles after the enabling write.
- R5: On each step, a counter equal to the live wrap value loads the live start value. Any other counter value increments by one. One full period is therefore wrap minus start plus one steps.
- R6: Control bit 7 is a sticky wrap flag. It is set on the step that reloads the start value.
- R7: A control write with bit 7 at 0 clears the flag. A control write with bit 7 at 1 leaves the flag as it was. If a clearing write and a wrap step fall on the same cycle, the flag stays set.
- R8: A write to the counter register loads the live start value into the counter, whatever the write data is.
- R9: Writes to the wrap and start registers land in shadow buffers, and reads of those registers return the buffers. The live values copy the buffers only while the source code is 0.
- R10: `irq_o` is a registered copy of (wrap flag AND control bit 6). It follows the flag and the enable one cycle late.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (8) | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; read data is valid in the same cycle |
| bus_rdata | output | 32 | Read data, zero when no read is made |
| irq_o | output | 1 | Wrap interrupt request |

## Verification
If the divider state is wrong, the counter read after a timed run is off by one or more steps. It shows on the first read after a run that is one cycle shorter or longer than a full prescaled period. If the live wrap or start value is copied at the wrong time, the counter reloads at the wrong point. That shows as a wrong count value and a wrong flag on the first wrap after software changes the buffer while the timer runs. A wrong flag or enable shows on `irq_o` one cycle after the change. A lost flag shows when a clearing write lands on the same cycle as a wrap step.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    // register byte addresses
    localparam logic [7:0] OFS_CTRL = 8'h00;
    localparam logic [7:0] OFS_CNT  = 8'h04;
    localparam logic [7:0] OFS_WRAP = 8'h08;
    localparam logic [7:0] OFS_BASE = 8'h4C;

    // control field geometry
    localparam int PS_W    = 3;
    localparam int PS_LSB  = 0;
    localparam int CS_W    = 2;
    localparam int CS_LSB  = 3;
    localparam int IE_BIT  = 6;
    localparam int FLG_BIT = 7;
    localparam int DATA_W  = 32;

    typedef enum logic [CS_W-1:0] {
        CS_OFF  = 2'd0,
        CS_SYS  = 2'd1,
        CS_RSV2 = 2'd2,
        CS_RSV3 = 2'd3
    } clksel_e;

    typedef struct packed {
        logic            flag;
        logic            ie;
        clksel_e         cs;
        logic [PS_W-1:0] ps;
    } ctrl_t;

    typedef struct packed {
        logic ctrl;
        logic cnt;
        logic wrap;
        logic base;
    } wsel_t;

    function automatic logic [DATA_W-1:0] pack_ctrl(input ctrl_t c);
        logic [DATA_W-1:0] r;
        r = '0;
        r[PS_LSB +: PS_W] = c.ps;
        r[CS_LSB +: CS_W] = c.cs;
        r[IE_BIT]         = c.ie;
        r[FLG_BIT]        = c.flag;
        return r;
    endfunction
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale
    import tmr_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            run,
    input  logic [PS_W-1:0] ps,
    output logic            tick
);
    localparam int DIV_W = (1 << PS_W) - 1;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] lim;

    assign lim  = DIV_W'((32'd1 << ps) - 32'd1);
    assign tick = run && (div_q >= lim);

    always_ff @(posedge clk) begin
        if (rst || !run || tick) div_q <= '0;
        else                     div_q <= div_q + 1'b1;
    end

    // R3
    stop_no_tick_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> (div_q == '0));
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] wrap_val,
    input  logic [CNT_W-1:0] base_val,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap_evt
);
    logic [CNT_W-1:0] cnt_q;
    logic             at_wrap;

    assign at_wrap  = (cnt_q == wrap_val);
    assign wrap_evt = tick && !load && at_wrap;
    assign cnt      = cnt_q;

    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (load) cnt_q <= base_val;
        else if (tick) cnt_q <= at_wrap ? base_val : cnt_q + 1'b1;
    end

    // R8
    load_base_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt_q == $past(base_val)));
    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick && !load) |=> $stable(cnt_q));
    // R5
    reload_chk: assert property (@(posedge clk) disable iff (rst)
        wrap_evt |=> (cnt_q == $past(base_val)));
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr,
    input  logic              rd,
    input  logic              wrap_evt,
    input  logic [CNT_W-1:0]  cnt_val,
    output logic [DATA_W-1:0] rdata,
    output logic [PS_W-1:0]   ps,
    output logic              run,
    output logic              cnt_load,
    output logic [CNT_W-1:0]  wrap_act,
    output logic [CNT_W-1:0]  base_act,
    output logic              irq
);
    ctrl_t            ctrl_q;
    wsel_t            ws;
    logic [CNT_W-1:0] wrap_buf, base_buf;
    logic             clr_req;
    logic             unused_wbits;

    assign unused_wbits = ^{wdata[DATA_W-1:CNT_W], wdata[5]};

    assign ws.ctrl = wr && (addr == ADDR_W'(OFS_CTRL));
    assign ws.cnt  = wr && (addr == ADDR_W'(OFS_CNT));
    assign ws.wrap = wr && (addr == ADDR_W'(OFS_WRAP));
    assign ws.base = wr && (addr == ADDR_W'(OFS_BASE));

    assign clr_req  = ws.ctrl && !wdata[FLG_BIT];
    assign ps       = ctrl_q.ps;
    assign run      = (ctrl_q.cs == CS_SYS);
    assign cnt_load = ws.cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            wrap_buf <= '0;
            base_buf <= '0;
            wrap_act <= '0;
            base_act <= '0;
            irq      <= 1'b0;
        end else begin
            if (ws.ctrl) begin
                ctrl_q.ps <= wdata[PS_LSB +: PS_W];
                ctrl_q.cs <= clksel_e'(wdata[CS_LSB +: CS_W]);
                ctrl_q.ie <= wdata[IE_BIT];
            end
            if (wrap_evt)     ctrl_q.flag <= 1'b1;
            else if (clr_req) ctrl_q.flag <= 1'b0;
            if (ws.wrap) wrap_buf <= wdata[CNT_W-1:0];
            if (ws.base) base_buf <= wdata[CNT_W-1:0];
            if (ctrl_q.cs == CS_OFF) begin
                wrap_act <= wrap_buf;
                base_act <= base_buf;
            end
            irq <= ctrl_q.flag && ctrl_q.ie;
        end
    end

    always_comb begin
        rdata = '0;
        if (rd) begin
            case (addr)
                ADDR_W'(OFS_CTRL): rdata = pack_ctrl(ctrl_q);
                ADDR_W'(OFS_CNT):  rdata = DATA_W'(cnt_val);
                ADDR_W'(OFS_WRAP): rdata = DATA_W'(wrap_buf);
                ADDR_W'(OFS_BASE): rdata = DATA_W'(base_buf);
                default:           rdata = '0;
            endcase
        end
    end

    // R6
    wrap_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
        wrap_evt |=> ctrl_q.flag);
    // R7
    flag_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (!wrap_evt && !clr_req) |=> $stable(ctrl_q.flag));
    // R9
    shadow_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.cs != CS_OFF) |=> ($stable(wrap_act) && $stable(base_act)));
    // R10
    irq_mask_chk: assert property (@(posedge clk) disable iff (rst)
        !ctrl_q.ie |=> !irq);
endmodule

// File: rtl/pscl_up_timer.sv
module pscl_up_timer
    import tmr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [31:0]       bus_rdata,
    output logic              irq_o
);
    logic [PS_W-1:0]  ps;
    logic             run, tick, cnt_load, wrap_evt;
    logic [CNT_W-1:0] wrap_act, base_act, cnt;

    tmr_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst(rst), .addr(bus_addr), .wdata(bus_wdata),
        .wr(bus_wr), .rd(bus_rd), .wrap_evt(wrap_evt), .cnt_val(cnt),
        .rdata(bus_rdata), .ps(ps), .run(run), .cnt_load(cnt_load),
        .wrap_act(wrap_act), .base_act(base_act), .irq(irq_o)
    );

    tmr_prescale u_pscl (
        .clk(clk), .rst(rst), .run(run), .ps(ps), .tick(tick)
    );

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .tick(tick), .load(cnt_load),
        .wrap_val(wrap_act), .base_val(base_act),
        .cnt(cnt), .wrap_evt(wrap_evt)
    );

    // R3
    stopped_cnt_chk: assert property (@(posedge clk) disable iff (rst)
        (!run && !cnt_load) |=> $stable(cnt));
endmodule

// File: tb/test_pscl_up_timer.sv
module test_pscl_up_timer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        irq_o;
    logic        probe = 1'b0;
    int          n_tests = 0;
    int          n_fail = 0;

    typedef struct packed {
        logic        is_irq;
        logic [7:0]  addr;
        logic [31:0] exp;
    } sb_t;
    sb_t   sb_q[$];
    string tag_q[$];

    always #2 clk = ~clk;

    pscl_up_timer i_pscl_up_timer (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    function automatic logic [31:0] cw(input int ps, input int cs, input bit ie, input bit keep);
        return {24'b0, keep, ie, 1'b0, cs[1:0], ps[2:0]};
    endfunction

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check_reg(input logic [7:0] a, input logic [31:0] e, input string tag);
        sb_q.push_back({1'b0, a, e});
        tag_q.push_back(tag);
        bus_addr = a; bus_rd = 1'b1;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic check_irq(input logic e, input string tag);
        sb_q.push_back({1'b1, 8'h00, {31'b0, e}});
        tag_q.push_back(tag);
        probe = 1'b1;
        @(posedge clk); #1;
        probe = 1'b0;
    endtask

    // monitor: pops expected items as results appear
    always @(negedge clk) begin
        if (bus_rd || probe) begin
            if (sb_q.size() == 0) begin
                n_tests++; n_fail++;
                $display("FAIL scoreboard empty: no expected item queued");
            end else begin
                sb_t         it;
                string       tg;
                logic [31:0] act;
                it  = sb_q.pop_front();
                tg  = tag_q.pop_front();
                act = it.is_irq ? {31'b0, irq_o} : bus_rdata;
                n_tests++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s addr=%h actual=%h expected=%h", tg, it.addr, act, it.exp);
                end
            end
        end
    end

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        // R1 reset state
        check_reg(8'h00, 32'h0, "R1 ctrl");
        check_reg(8'h04, 32'h0, "R1 cnt");
        check_reg(8'h08, 32'h0, "R1 wrap");
        check_reg(8'h4C, 32'h0, "R1 base");
        check_irq(1'b0, "R1 irq");

        // R2 upper bits dropped
        bus_write(8'h4C, 32'hFFFF_0003);
        bus_write(8'h08, 32'h0000_0006);
        check_reg(8'h4C, 32'h3, "R2 base");
        check_reg(8'h08, 32'h6, "R2 wrap");
        // R8 counter write loads start value
        bus_write(8'h04, 32'h0000_DEAD);
        check_reg(8'h04, 32'h3, "R8 cnt");

        // R3 R5 R6 one period of 4 steps
        bus_write(8'h00, cw(0, 1, 1, 1));
        idle(3);
        bus_write(8'h00, cw(0, 0, 1, 1));
        check_reg(8'h04, 32'h3, "R5 reload");
        check_reg(8'h00, 32'hC0, "R6 flag");
        check_irq(1'b1, "R10 irq high");

        // R7 flag write semantics
        bus_write(8'h00, cw(0, 0, 1, 1));
        check_reg(8'h00, 32'hC0, "R7 keep");
        bus_write(8'h00, cw(0, 0, 1, 0));
        check_reg(8'h00, 32'h40, "R7 clear");
        idle(1);
        check_irq(1'b0, "R10 irq low");

        // R3 reserved source code holds
        bus_write(8'h00, cw(0, 2, 0, 1));
        idle(5);
        bus_write(8'h00, cw(0, 0, 0, 1));
        check_reg(8'h04, 32'h3, "R3 hold");

        // R4 divide by 4, first step after 4 cycles
        bus_write(8'h00, cw(2, 1, 0, 1));
        idle(6);
        bus_write(8'h00, cw(2, 0, 0, 1));
        check_reg(8'h04, 32'h4, "R4 div4");

        // R4 divide by 128 boundary
        bus_write(8'h04, 32'h0);
        bus_write(8'h00, cw(7, 1, 0, 1));
        idle(126);
        bus_write(8'h00, cw(7, 0, 0, 1));
        check_reg(8'h04, 32'h3, "R4 div128 short");
        bus_write(8'h00, cw(7, 1, 0, 1));
        idle(127);
        bus_write(8'h00, cw(7, 0, 0, 1));
        check_reg(8'h04, 32'h4, "R4 div128 full");

        // R9 shadow wrap value while running
        bus_write(8'h04, 32'h0);
        bus_write(8'h00, cw(0, 1, 0, 1));
        bus_write(8'h08, 32'h9);
        idle(2);
        bus_write(8'h00, cw(0, 0, 0, 1));
        check_reg(8'h04, 32'h3, "R9 old wrap");
        check_reg(8'h08, 32'h9, "R9 buffer read");
        bus_write(8'h04, 32'h0);
        bus_write(8'h00, cw(0, 1, 0, 1));
        idle(3);
        bus_write(8'h00, cw(0, 0, 0, 1));
        check_reg(8'h04, 32'h7, "R9 new wrap");

        // R7 clear and wrap on the same cycle
        bus_write(8'h00, cw(0, 0, 0, 0));
        check_reg(8'h00, 32'h0, "R7 pre-clear");
        bus_write(8'h04, 32'h0);
        bus_write(8'h00, cw(0, 1, 0, 0));
        idle(6);
        bus_write(8'h00, cw(0, 1, 0, 0));
        bus_write(8'h00, cw(0, 0, 0, 1));
        check_reg(8'h00, 32'h80, "R7 collide");
        check_reg(8'h04, 32'h4, "R5 after wrap");

        idle(2);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule